// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Aggregator

This block gathers 32 interrupt sources into a single processor interrupt line. Each source position is fixed at build time as either level-sensitive, where the status bit follows the synchronized input, or edge-latched, where a rising edge sets a sticky bit that stays set until software clears it. Three positions carry the group summaries of a cascaded secondary controller, and three positions can also be raised by software. The assembled status word is gated by an enable mask. The line is raised whenever any enabled bit is set, and the index of the lowest-numbered enabled bit is reported next to it.

Software reaches the block through a small register port with four word registers: a read-only status view, the enable mask, a hardware view through which latched edge bits are cleared, and a software-request register. A read returns its data on the clock edge that follows the request.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable mask, the software-request register and every edge latch are zero, the interrupt line and the index-valid flag are low, and the read data is zero.
- R2: A level-sensitive position shows its input, after a two-flop synchronizer, in the status word and stores nothing: when the input falls, the status bit falls too.
- R3: Positions 16-19, 22-24 and 28-31 are edge-latched. A rising edge of the synchronized input sets the bit, and it stays set after the input falls.
- R4: Writing the hardware view register (address 2) clears every latched edge bit whose written value is 0 and keeps every bit written as 1. A write cannot set a bit and does not affect level positions.
- R5: When a rising edge and a clearing write reach the same edge bit in the same cycle, the bit ends up set.
- R6: The software-request register (address 3) stores only bits 28-30, which are ORed into the status word. Its other bits read as 0 and do not affect the status word.
- R7: The cascade summary inputs drive status positions 4 (peripheral I/O, cascade bit 0), 5 (miscellaneous, cascade bit 1) and 6 (audio, cascade bit 2) as level sources. Bits 4-6 of the direct source input are ignored.
- R8: The enable mask (address 1, read/write) gates the status word. The interrupt line is high exactly when status AND mask is nonzero.
- R9: The index output gives the lowest-numbered bit of status AND mask, with index-valid high. When that set is empty, index-valid is low and the index is 0.
- R10: Address 0 returns the status word and ignores writes. Read data is registered and appears the cycle after a read request. It holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_src_i | input | 32 | Direct hardware sources (bits 4-6 unused) |
| casc_sum_i | input | 3 | Secondary controller group summaries |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 hardware view, 3 software request |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | Processor interrupt line |
| irq_idx_o | output | 5 | Lowest pending source index |
| irq_idx_valid_o | output | 1 | Index is meaningful (pending set nonzero) |

## Verification
The hardest situation to reach from the ports is the collision of R5. The rising edge has to leave the last synchronizer stage in the same cycle that a clearing write to the hardware view register is sampled. The bench raises the source on one falling clock edge and counts exactly two rising edges through the synchronizer. It then presents the clearing write so that it is sampled on the third edge, which is the edge on which the latch is set. It reads the latch back afterwards, then repeats the clearing write without a new edge to show that the same write does clear the bit when nothing collides with it.

// File: rtl/irq_agg_pkg.sv
// Package: shared register-select encoding for the interrupt aggregator.
// Assumes a two-bit register address on the access port.
package irq_agg_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_HWVIEW = 2'd2,
        SEL_SWREQ  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_sync.sv
// irq_sync: multi-stage synchronizer for a vector of asynchronous sources,
// plus a one-cycle rising-edge pulse on the synchronized value.
// Assumes each input is held for at least one clock period to be seen.
module irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    // Shift the raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                stg_q[s] <= '0;
            end
        end else begin
            stg_q[0] <= async_i;
            for (int s = 1; s < int'(STAGES); s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    // Remember the last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irq_latch.sv
// irq_latch: per-bit selection between a sticky edge latch and a plain
// level pass-through, chosen by EDGE_MASK at build time.
// Assumes clr_i is a one-cycle pulse vector; a rise in the same cycle wins.
module irq_latch #(
    parameter int unsigned W         = 32,
    parameter logic [W-1:0] EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] hw_o
);

    for (genvar i = 0; i < int'(W); i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic hold_q;
            // Sticky latch: set on rising edge, cleared by request, set wins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= 1'b0;
                end else begin
                    hold_q <= (hold_q & ~clr_i[i]) | rise_i[i];
                end
            end
            assign hw_o[i] = hold_q;
        end else begin : g_level
            assign hw_o[i] = lvl_i[i];
        end
    end

endmodule

// File: rtl/irq_regs.sv
// irq_regs: register file and access port. It holds the enable mask and the
// software request bits, issues clear pulses for edge latches, and returns
// registered read data. Assumes one access per cycle on the port.
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned W       = 32,
    parameter logic [W-1:0] SW_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic         write_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] hwview_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] swreq_o,
    output logic [W-1:0] clr_o,
    output logic [W-1:0] rdata_o
);

    reg_sel_e     sel;
    logic         wr_en;
    logic         rd_en;
    logic [W-1:0] mask_q;
    logic [W-1:0] swreq_q;
    logic [W-1:0] rd_mux;

    assign sel   = reg_sel_e'(addr_i);
    assign wr_en = valid_i & write_i;
    assign rd_en = valid_i & ~write_i;

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && sel == SEL_MASK) begin
            mask_q <= wdata_i;
        end
    end

    // Software request register, only the permitted bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swreq_q <= '0;
        end else if (wr_en && sel == SEL_SWREQ) begin
            swreq_q <= wdata_i & SW_MASK;
        end
    end

    // Clear pulse: zeros written to the hardware view clear latches.
    always_comb begin
        clr_o = '0;
        if (wr_en && sel == SEL_HWVIEW) begin
            clr_o = ~wdata_i;
        end
    end

    // Read multiplexer over the four registers.
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status_i;
            SEL_MASK:   rd_mux = mask_q;
            SEL_HWVIEW: rd_mux = hwview_i;
            SEL_SWREQ:  rd_mux = swreq_q;
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data, updated only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en) begin
            rdata_o <= rd_mux;
        end
    end

    assign mask_o  = mask_q;
    assign swreq_o = swreq_q;

endmodule

// File: rtl/irq_prio.sv
// irq_prio: lowest-index priority encoder over the pending vector.
// Assumes index 0 is highest priority; reports 0 when nothing is pending.
module irq_prio #(
    parameter int unsigned W    = 32,
    parameter int unsigned IDXW = $clog2(W)
) (
    input  logic [W-1:0]    pend_i,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);

    // Scan from the top down so the lowest set bit is the final winner.
    always_comb begin
        idx_o = '0;
        for (int i = int'(W) - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDXW'(i);
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/irq_aggregator.sv
// irq_aggregator: top level. It merges the direct sources with the cascade
// summaries, synchronizes them, applies edge latching, ORs in the software
// requests, gates the result with the mask and drives the line and the index.
// Assumes all sources are asynchronous to clk.
module irq_aggregator #(
    parameter int unsigned    NSRC        = 32,
    parameter int unsigned    NCASC       = 3,
    parameter int unsigned    CASC_LSB    = 4,
    parameter int unsigned    SYNC_STAGES = 2,
    parameter logic [NSRC-1:0] EDGE_MASK  = 32'hF1CF_0000,
    parameter logic [NSRC-1:0] SW_MASK    = 32'h7000_0000,
    localparam int unsigned   IDXW        = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_src_i,
    input  logic [NCASC-1:0] casc_sum_i,
    input  logic            bus_valid_i,
    input  logic            bus_write_i,
    input  logic [1:0]      bus_addr_i,
    input  logic [NSRC-1:0] bus_wdata_i,
    output logic [NSRC-1:0] bus_rdata_o,
    output logic            cpu_irq_o,
    output logic [IDXW-1:0] irq_idx_o,
    output logic            irq_idx_valid_o
);

    logic [NSRC-1:0] raw_w;
    logic [NSRC-1:0] sync_w;
    logic [NSRC-1:0] rise_w;
    logic [NSRC-1:0] clr_w;
    logic [NSRC-1:0] hwview_w;
    logic [NSRC-1:0] mask_w;
    logic [NSRC-1:0] swreq_w;
    logic [NSRC-1:0] status_w;
    logic [NSRC-1:0] pend_w;
    logic            any_w;

    // Replace the cascade positions of the direct input with the summaries.
    for (genvar i = 0; i < int'(NSRC); i++) begin : g_merge
        if (i >= int'(CASC_LSB) && i < int'(CASC_LSB + NCASC)) begin : g_casc
            assign raw_w[i] = casc_sum_i[i - int'(CASC_LSB)];
        end else begin : g_direct
            assign raw_w[i] = hw_src_i[i];
        end
    end

    irq_sync #(
        .W      (NSRC),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_w),
        .sync_o  (sync_w),
        .rise_o  (rise_w)
    );

    irq_latch #(
        .W         (NSRC),
        .EDGE_MASK (EDGE_MASK)
    ) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_w),
        .rise_i (rise_w),
        .clr_i  (clr_w),
        .hw_o   (hwview_w)
    );

    assign status_w = hwview_w | swreq_w;
    assign pend_w   = status_w & mask_w;

    irq_regs #(
        .W       (NSRC),
        .SW_MASK (SW_MASK)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (bus_valid_i),
        .write_i  (bus_write_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status_w),
        .hwview_i (hwview_w),
        .mask_o   (mask_w),
        .swreq_o  (swreq_w),
        .clr_o    (clr_w),
        .rdata_o  (bus_rdata_o)
    );

    irq_prio #(
        .W    (NSRC),
        .IDXW (IDXW)
    ) prio_i (
        .pend_i (pend_w),
        .idx_o  (irq_idx_o),
        .any_o  (any_w)
    );

    assign cpu_irq_o       = any_w;
    assign irq_idx_valid_o = any_w;

endmodule

// File: rtl/irq_aggregator_chk.sv
// irq_aggregator_chk: property checker bound into irq_aggregator.
// Assumes it observes the internal vectors named in the bind below.
module irq_aggregator_chk #(
    parameter int unsigned     W         = 32,
    parameter int unsigned     IDXW      = 5,
    parameter logic [W-1:0]    EDGE_MASK = '0,
    parameter logic [W-1:0]    SW_MASK   = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [W-1:0]    sync_w,
    input logic [W-1:0]    rise_w,
    input logic [W-1:0]    clr_w,
    input logic [W-1:0]    hwview_w,
    input logic [W-1:0]    status_w,
    input logic [W-1:0]    mask_w,
    input logic [W-1:0]    swreq_w,
    input logic [W-1:0]    pend_w,
    input logic            cpu_irq_o,
    input logic [IDXW-1:0] irq_idx_o,
    input logic            irq_idx_valid_o
);

    logic [W-1:0] below_w;
    assign below_w = (W'(1) << irq_idx_o) - W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_w == '0 && swreq_w == '0 && (hwview_w & EDGE_MASK) == '0));

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w & ~EDGE_MASK) == (sync_w & ~EDGE_MASK));

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hwview_w) & ~hwview_w & EDGE_MASK & ~$past(clr_w)) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise_w) & EDGE_MASK & ~hwview_w) == '0));

    // R6
    sw_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swreq_w & ~SW_MASK) == '0);

    // R8
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o == (pend_w != '0));

    // R9
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_valid_o |-> (pend_w[irq_idx_o] && (pend_w & below_w) == '0));

    // R9
    idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_idx_valid_o |-> (irq_idx_o == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .W         (NSRC),
    .IDXW      (IDXW),
    .EDGE_MASK (EDGE_MASK),
    .SW_MASK   (SW_MASK)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .sync_w          (sync_w),
    .rise_w          (rise_w),
    .clr_w           (clr_w),
    .hwview_w        (hwview_w),
    .status_w        (status_w),
    .mask_w          (mask_w),
    .swreq_w         (swreq_w),
    .pend_w          (pend_w),
    .cpu_irq_o       (cpu_irq_o),
    .irq_idx_o       (irq_idx_o),
    .irq_idx_valid_o (irq_idx_valid_o)
);

// File: tb/irq_aggregator_tb_top.sv
// Bench for irq_aggregator: a vector table for level and cascade sources,
// then directed tests for reset, edge latching, clearing and software bits.
module irq_aggregator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_src = '0;
    logic [2:0]  casc = '0;
    logic        bv = 1'b0;
    logic        bw = 1'b0;
    logic [1:0]  ba = '0;
    logic [31:0] bd = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [4:0]  idx;
    logic        idxv;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .hw_src_i        (hw_src),
        .casc_sum_i      (casc),
        .bus_valid_i     (bv),
        .bus_write_i     (bw),
        .bus_addr_i      (ba),
        .bus_wdata_i     (bd),
        .bus_rdata_o     (rdata),
        .cpu_irq_o       (irq),
        .irq_idx_o       (idx),
        .irq_idx_valid_o (idxv)
    );

    typedef struct packed {
        logic [31:0] hw;
        logic [2:0]  sub;
        logic [31:0] msk;
        logic        exp_irq;
        logic [4:0]  exp_idx;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 3'b000, 32'hFFFF_FFFF, 1'b1, 5'd0},
        '{32'h0000_0300, 3'b000, 32'h0000_0200, 1'b1, 5'd9},
        '{32'h0000_0070, 3'b000, 32'hFFFF_FFFF, 1'b0, 5'd0},
        '{32'h0000_0000, 3'b100, 32'h0000_0040, 1'b1, 5'd6},
        '{32'h0820_0000, 3'b011, 32'h0820_0000, 1'b1, 5'd21},
        '{32'h0C00_0080, 3'b000, 32'h0000_0000, 1'b0, 5'd0},
        '{32'h0010_0000, 3'b010, 32'h0010_0020, 1'b1, 5'd5}
    };

    // Level view expected from R2/R7: edge and cascade positions removed.
    function automatic logic [31:0] lvl_status(logic [31:0] h, logic [2:0] s);
        return (h & ~32'hF1CF_0070) | ({29'd0, s} << 4);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bv = 1'b1; bw = 1'b1; ba = a; bd = d;
        @(negedge clk);
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bv = 1'b1; bw = 1'b0; ba = a;
        @(negedge clk);
        bv = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check(irq == 1'b0 && idxv == 1'b0, "R1 line", {30'd0, irq, idxv}, 32'd0);
        check(rdata == 32'd0, "R1 rdata", rdata, 32'd0);
        rd(2'd1, v); check(v == 32'd0, "R1 mask", v, 32'd0);
        rd(2'd2, v); check(v == 32'd0, "R1 hwview", v, 32'd0);
        rd(2'd3, v); check(v == 32'd0, "R1 swreq", v, 32'd0);

        // R2 R7 R8 R9 vector table of level and cascade patterns
        for (int k = 0; k < NV; k++) begin
            wr(2'd1, VECS[k].msk);
            hw_src = VECS[k].hw;
            casc   = VECS[k].sub;
            idle(4);
            check(irq == VECS[k].exp_irq, "R8 line", {31'd0, irq}, {31'd0, VECS[k].exp_irq});
            check(idxv == VECS[k].exp_irq && idx == VECS[k].exp_idx, "R9 index",
                  {26'd0, idxv, idx}, {26'd0, VECS[k].exp_irq, VECS[k].exp_idx});
            rd(2'd0, v);
            check(v == lvl_status(VECS[k].hw, VECS[k].sub), "R7 status", v,
                  lvl_status(VECS[k].hw, VECS[k].sub));
        end

        // R2 level bits store nothing
        hw_src = '0; casc = '0;
        idle(4);
        rd(2'd0, v); check(v == 32'd0, "R2 level drop", v, 32'd0);
        check(irq == 1'b0 && idx == 5'd0, "R9 empty", {26'd0, irq, idx}, 32'd0);

        // R3 edge latch holds after a pulse on bit 17
        wr(2'd1, 32'hFFFF_FFFF);
        hw_src[17] = 1'b1; idle(2); hw_src[17] = 1'b0;
        idle(5);
        check(irq && idxv && idx == 5'd17, "R3 edge index", {26'd0, irq, idx}, {26'd0, 1'b1, 5'd17});
        rd(2'd2, v); check(v == 32'h0002_0000, "R3 latched", v, 32'h0002_0000);

        // R4 clear bit 17 by writing 0 there
        wr(2'd2, 32'hFFFD_FFFF);
        idle(1);
        rd(2'd2, v); check(v == 32'd0, "R4 clear", v, 32'd0);
        check(irq == 1'b0, "R4 line low", {31'd0, irq}, 32'd0);

        // R4 selective clear: latch 16 and 18, clear only 16
        hw_src[16] = 1'b1; hw_src[18] = 1'b1; idle(2);
        hw_src[16] = 1'b0; hw_src[18] = 1'b0; idle(5);
        wr(2'd2, 32'hFFFE_FFFF);
        rd(2'd2, v); check(v == 32'h0004_0000, "R4 keep ones", v, 32'h0004_0000);
        wr(2'd2, 32'h0000_0000);
        rd(2'd2, v); check(v == 32'd0, "R4 clear all", v, 32'd0);

        // R4 write cannot set, and level bits ignore it
        hw_src[8] = 1'b1; idle(4);
        wr(2'd2, 32'h0000_0000);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check(v == 32'h0000_0100, "R4 no set, level kept", v, 32'h0000_0100);
        hw_src[8] = 1'b0; idle(4);

        // R5 rising edge and clearing write land in the same cycle
        @(negedge clk); hw_src[19] = 1'b1;
        @(negedge clk);
        @(negedge clk); bv = 1'b1; bw = 1'b1; ba = 2'd2; bd = 32'hFFF7_FFFF;
        @(negedge clk); bv = 1'b0; bw = 1'b0;
        hw_src[19] = 1'b0;
        rd(2'd2, v); check(v == 32'h0008_0000, "R5 set wins", v, 32'h0008_0000);
        wr(2'd2, 32'hFFF7_FFFF);
        rd(2'd2, v); check(v == 32'd0, "R5 later clear", v, 32'd0);

        // R6 software request bits
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check(v == 32'h7000_0000, "R6 stored bits", v, 32'h7000_0000);
        rd(2'd0, v); check(v == 32'h7000_0000, "R6 status", v, 32'h7000_0000);
        check(irq && idx == 5'd28, "R6 index", {26'd0, irq, idx}, {26'd0, 1'b1, 5'd28});
        wr(2'd1, 32'h4000_0000);
        idle(1);
        check(irq && idx == 5'd30, "R6 masked index", {26'd0, irq, idx}, {26'd0, 1'b1, 5'd30});
        wr(2'd3, 32'h0000_0000);
        rd(2'd0, v); check(v == 32'd0, "R6 cleared", v, 32'd0);
        check(irq == 1'b0, "R6 line low", {31'd0, irq}, 32'd0);

        // R10 status ignores writes, read data holds between reads
        hw_src[2] = 1'b1; idle(4);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check(v == 32'h0000_0004, "R10 status read only", v, 32'h0000_0004);
        hw_src[2] = 1'b0; idle(4);
        check(rdata == 32'h0000_0004, "R10 rdata hold", rdata, 32'h0000_0004);
        rd(2'd1, v); check(v == 32'h4000_0000, "R10 mask readback", v, 32'h4000_0000);

        // R1 reset again clears mask and latches
        hw_src[31] = 1'b1; idle(2); hw_src[31] = 1'b0; idle(5);
        @(negedge clk); rst_n = 1'b0;
        idle(2); rst_n = 1'b1;
        idle(1);
        check(rdata == 32'd0 && irq == 1'b0, "R1 rerst", rdata, 32'd0);
        rd(2'd2, v); check(v == 32'd0, "R1 latch cleared", v, 32'd0);
        rd(2'd1, v); check(v == 32'd0, "R1 mask cleared", v, 32'd0);

        finish_run();
    end

endmodule